// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node for a range of memory blocks in a shared-memory multiprocessor. For each block it holds a directory entry and the backing data word. The entry has a state (uncached, shared or exclusive) and a sharer bit vector with one bit per processor. Requesters send read misses, write misses and write-backs on a valid/ready request channel. The controller replies on a single valid/ready message channel, which carries data replies, invalidations and owner fetches. Every message has a destination bit mask, so one invalidation message reaches all of its targets at once.

A request to an exclusive block needs data from the owner. A write request to a block that other caches share needs their copies removed first. In both cases the controller opens one outstanding transaction and waits for answers on a separate response channel. A response is either an invalidation acknowledgement or the owner's data. Requests to the block under transaction are held back, which keeps writes to one block in arrival order. Requests to other blocks that need no wait are still served. Write permission is sent only after the last acknowledgement has arrived.

Top module: `dirc_home`

## Requirements
- R1: After reset every entry is uncached with an empty sharer vector, and the memory word of block i is 3*i+1 (truncated to the data width). `msg_valid` is low, `req_ready` is high and `rsp_ready` is low.
- R2: A read miss (`req_kind`=0) to an uncached or shared block sends, one cycle later, a shared-data message (`msg_kind`=0) to the requester only, carrying the memory word. The block becomes shared and the requester is added to the sharer vector.
- R3: A write miss (`req_kind`=1) to an uncached block sends an exclusive-data message (`msg_kind`=1) to the requester with the memory word. The block becomes exclusive with the requester as its only owner.
- R4: A write-back (`req_kind`=2) stores `req_data` into the block's memory word, makes the block uncached, clears its sharer vector and sends no message.
- R5: A write miss to a shared block that has sharers other than the requester sends one invalidation message (`msg_kind`=2) whose mask holds exactly those other sharers. Acknowledgements that leave some target still pending produce no message. The last one produces the exclusive-data message to the requester, and the block becomes exclusive with the requester as owner.
- R6: A write miss from the only sharer of a block is granted at once with an exclusive-data message and needs no acknowledgement.
- R7: A read miss to an exclusive block sends a fetch message (`msg_kind`=3) to the owner. The owner's response data is written to memory and returned to the requester in a shared-data message. Both the old owner and the requester then become sharers.
- R8: A write miss to an exclusive block sends a fetch to the owner. The owner's response data is returned to the requester in an exclusive-data message, and the requester becomes the new owner.
- R9: While a transaction is outstanding, a request to its block sees `req_ready` low. A request to another block that needs neither fetch nor invalidation is accepted.
- R10: While `msg_valid` is high and `msg_ready` is low, the message fields stay unchanged, and requests that would emit a message are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(N_PROC) | Requesting processor index |
| req_blk | input | $clog2(N_BLOCKS) | Block index |
| req_data | input | DATA_W | Write-back data |
| rsp_valid | input | 1 | Acknowledgement or owner data present |
| rsp_ready | output | 1 | Response accepted this cycle when valid |
| rsp_src | input | $clog2(N_PROC) | Responding processor index |
| rsp_data | input | DATA_W | Owner data for a fetch |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Receiver takes the message |
| msg_kind | output | 2 | 0 shared data, 1 exclusive data, 2 invalidate, 3 fetch |
| msg_mask | output | N_PROC | Destination processors, one bit each |
| msg_blk | output | $clog2(N_BLOCKS) | Block the message concerns |
| msg_data | output | DATA_W | Data payload |

## Verification
The bench targets ordering around the outstanding transaction. If a design granted write permission on the first acknowledgement, a message would appear after a partial set of acknowledgements. If it let a same-block request in early, `req_ready` would rise during the wait. If it left the requester in its own invalidation mask, that mask would read 0111 instead of 0011, for example. A design that failed to copy the owner's fetched data into memory would return the stale word on the following plain read. A design that dropped the old owner from the sharer vector would leave it out of the next invalidation mask.

// File: rtl/dirc_pkg.sv
`timescale 1ns/1ps
package dirc_pkg;

    typedef enum logic [1:0] {
        ST_UNC = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2
    } dstate_t;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2
    } rkind_t;

    typedef enum logic [1:0] {
        MS_DATA_SH = 2'd0,
        MS_DATA_EX = 2'd1,
        MS_INVAL   = 2'd2,
        MS_FETCH   = 2'd3
    } mkind_t;

    // initial memory contents of a block after reset
    function automatic int seed_value(int idx);
        return idx * 3 + 1;
    endfunction

endpackage

// File: rtl/dirc_store.sv
`timescale 1ns/1ps
module dirc_store
    import dirc_pkg::*;
#(
    parameter int N_PROC   = 4,
    parameter int N_BLOCKS = 8,
    parameter int DATA_W   = 16,
    localparam int BLK_W   = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BLK_W-1:0]  ra_blk,
    output dstate_t           ra_st,
    output logic [N_PROC-1:0] ra_shr,
    output logic [DATA_W-1:0] ra_mem,
    input  logic [BLK_W-1:0]  rb_blk,
    output logic [DATA_W-1:0] rb_mem,
    input  logic              we,
    input  logic [BLK_W-1:0]  w_blk,
    input  dstate_t           w_st,
    input  logic [N_PROC-1:0] w_shr,
    input  logic              wm_en,
    input  logic [DATA_W-1:0] wm_data
);

    dstate_t           dir_st  [N_BLOCKS];
    logic [N_PROC-1:0] dir_shr [N_BLOCKS];
    logic [DATA_W-1:0] mem     [N_BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_BLOCKS; i++) begin
                dir_st[i]  <= ST_UNC;
                dir_shr[i] <= '0;
                mem[i]     <= DATA_W'(seed_value(i));
            end
        end else begin
            if (we) begin
                dir_st[w_blk]  <= w_st;
                dir_shr[w_blk] <= w_shr;
            end
            if (wm_en) begin
                mem[w_blk] <= wm_data;
            end
        end
    end

    assign ra_st  = dir_st[ra_blk];
    assign ra_shr = dir_shr[ra_blk];
    assign ra_mem = mem[ra_blk];
    assign rb_mem = mem[rb_blk];

    // R3 R8
    exc_single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (ra_st == ST_EXC) |-> ($countones(ra_shr) == 1));

    // R4
    unc_no_sharer_chk: assert property (@(posedge clk) disable iff (rst)
        (ra_st == ST_UNC) |-> (ra_shr == '0));

endmodule

// File: rtl/dirc_decide.sv
`timescale 1ns/1ps
module dirc_decide
    import dirc_pkg::*;
#(
    parameter int N_PROC = 4,
    parameter int DATA_W = 16,
    localparam int SRC_W = $clog2(N_PROC)
) (
    input  logic [1:0]        kind,
    input  logic [SRC_W-1:0]  src,
    input  dstate_t           st,
    input  logic [N_PROC-1:0] shr,
    input  logic [DATA_W-1:0] mem,
    output logic              upd,
    output dstate_t           n_st,
    output logic [N_PROC-1:0] n_shr,
    output logic              mem_wr,
    output logic              need_pend,
    output logic              fetch,
    output logic [N_PROC-1:0] wait_mask,
    output logic              emit,
    output mkind_t            m_kind,
    output logic [N_PROC-1:0] m_mask,
    output logic [DATA_W-1:0] m_data
);

    logic [N_PROC-1:0] src_bit;
    logic [N_PROC-1:0] others;

    assign src_bit = N_PROC'(1) << src;
    assign others  = shr & ~src_bit;

    always_comb begin
        upd       = 1'b0;
        n_st      = st;
        n_shr     = shr;
        mem_wr    = 1'b0;
        need_pend = 1'b0;
        fetch     = 1'b0;
        wait_mask = '0;
        emit      = 1'b0;
        m_kind    = MS_DATA_SH;
        m_mask    = src_bit;
        m_data    = mem;
        case (rkind_t'(kind))
            RQ_READ: begin
                emit = 1'b1;
                if (st == ST_EXC) begin
                    need_pend = 1'b1;
                    fetch     = 1'b1;
                    wait_mask = shr;
                    m_kind    = MS_FETCH;
                    m_mask    = shr;
                    m_data    = '0;
                end else begin
                    upd    = 1'b1;
                    n_st   = ST_SHR;
                    n_shr  = (st == ST_UNC) ? src_bit : (shr | src_bit);
                    m_kind = MS_DATA_SH;
                end
            end
            RQ_WRITE: begin
                emit = 1'b1;
                if (st == ST_EXC) begin
                    need_pend = 1'b1;
                    fetch     = 1'b1;
                    wait_mask = shr;
                    m_kind    = MS_FETCH;
                    m_mask    = shr;
                    m_data    = '0;
                end else if (st == ST_SHR && others != '0) begin
                    need_pend = 1'b1;
                    wait_mask = others;
                    m_kind    = MS_INVAL;
                    m_mask    = others;
                    m_data    = '0;
                end else begin
                    upd    = 1'b1;
                    n_st   = ST_EXC;
                    n_shr  = src_bit;
                    m_kind = MS_DATA_EX;
                end
            end
            RQ_WBACK: begin
                upd    = 1'b1;
                mem_wr = 1'b1;
                n_st   = ST_UNC;
                n_shr  = '0;
            end
            default: begin
                upd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dirc_outq.sv
`timescale 1ns/1ps
module dirc_outq
    import dirc_pkg::*;
#(
    parameter int N_PROC   = 4,
    parameter int N_BLOCKS = 8,
    parameter int DATA_W   = 16,
    localparam int BLK_W   = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  mkind_t            l_kind,
    input  logic [N_PROC-1:0] l_mask,
    input  logic [BLK_W-1:0]  l_blk,
    input  logic [DATA_W-1:0] l_data,
    output logic              slot_free,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_kind,
    output logic [N_PROC-1:0] msg_mask,
    output logic [BLK_W-1:0]  msg_blk,
    output logic [DATA_W-1:0] msg_data
);

    logic              q_v;
    mkind_t            q_kind;
    logic [N_PROC-1:0] q_mask;
    logic [BLK_W-1:0]  q_blk;
    logic [DATA_W-1:0] q_data;

    assign slot_free = !q_v || msg_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_v    <= 1'b0;
            q_kind <= MS_DATA_SH;
            q_mask <= '0;
            q_blk  <= '0;
            q_data <= '0;
        end else if (load) begin
            q_v    <= 1'b1;
            q_kind <= l_kind;
            q_mask <= l_mask;
            q_blk  <= l_blk;
            q_data <= l_data;
        end else if (msg_ready) begin
            q_v <= 1'b0;
        end
    end

    assign msg_valid = q_v;
    assign msg_kind  = q_kind;
    assign msg_mask  = q_mask;
    assign msg_blk   = q_blk;
    assign msg_data  = q_data;

    // R10
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q_v && !msg_ready) |=> (q_v && $stable(q_mask) && $stable(q_kind) && $stable(q_data)));

    // R10
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> slot_free);

    // R2 R5
    msg_has_target_chk: assert property (@(posedge clk) disable iff (rst)
        q_v |-> (q_mask != '0));

endmodule

// File: rtl/dirc_home.sv
`timescale 1ns/1ps
module dirc_home
    import dirc_pkg::*;
#(
    parameter int N_PROC   = 4,
    parameter int N_BLOCKS = 8,
    parameter int DATA_W   = 16,
    localparam int SRC_W   = $clog2(N_PROC),
    localparam int BLK_W   = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [SRC_W-1:0]  rsp_src,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_kind,
    output logic [N_PROC-1:0] msg_mask,
    output logic [BLK_W-1:0]  msg_blk,
    output logic [DATA_W-1:0] msg_data
);

    // directory read data
    dstate_t           cur_st;
    logic [N_PROC-1:0] cur_shr;
    logic [DATA_W-1:0] cur_mem;
    logic [DATA_W-1:0] pend_mem;

    // decision for the incoming request
    logic              d_upd, d_mem_wr, d_need_pend, d_fetch, d_emit;
    dstate_t           d_st;
    logic [N_PROC-1:0] d_shr, d_wait, d_mask;
    mkind_t            d_kind;
    logic [DATA_W-1:0] d_data;

    // outstanding transaction
    logic              pend_v;
    logic [BLK_W-1:0]  pend_blk;
    logic [N_PROC-1:0] pend_req;
    logic              pend_read;
    logic              pend_fetch;
    logic [N_PROC-1:0] pend_wait;
    logic [N_PROC-1:0] pend_owner;

    logic              slot_free;
    logic              rsp_fire, req_fire, finish;
    logic [N_PROC-1:0] rsp_bit, wait_next;
    logic              blocked;

    // store write port
    logic              we, wm_en;
    logic [BLK_W-1:0]  w_blk;
    dstate_t           w_st;
    logic [N_PROC-1:0] w_shr;
    logic [DATA_W-1:0] wm_data;

    // output load
    logic              o_load;
    mkind_t            o_kind;
    logic [N_PROC-1:0] o_mask;
    logic [BLK_W-1:0]  o_blk;
    logic [DATA_W-1:0] o_data;

    dirc_store #(.N_PROC(N_PROC), .N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .ra_blk  (req_blk),
        .ra_st   (cur_st),
        .ra_shr  (cur_shr),
        .ra_mem  (cur_mem),
        .rb_blk  (pend_blk),
        .rb_mem  (pend_mem),
        .we      (we),
        .w_blk   (w_blk),
        .w_st    (w_st),
        .w_shr   (w_shr),
        .wm_en   (wm_en),
        .wm_data (wm_data)
    );

    dirc_decide #(.N_PROC(N_PROC), .DATA_W(DATA_W)) u_decide (
        .kind      (req_kind),
        .src       (req_src),
        .st        (cur_st),
        .shr       (cur_shr),
        .mem       (cur_mem),
        .upd       (d_upd),
        .n_st      (d_st),
        .n_shr     (d_shr),
        .mem_wr    (d_mem_wr),
        .need_pend (d_need_pend),
        .fetch     (d_fetch),
        .wait_mask (d_wait),
        .emit      (d_emit),
        .m_kind    (d_kind),
        .m_mask    (d_mask),
        .m_data    (d_data)
    );

    dirc_outq #(.N_PROC(N_PROC), .N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W)) u_outq (
        .clk       (clk),
        .rst       (rst),
        .load      (o_load),
        .l_kind    (o_kind),
        .l_mask    (o_mask),
        .l_blk     (o_blk),
        .l_data    (o_data),
        .slot_free (slot_free),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_kind  (msg_kind),
        .msg_mask  (msg_mask),
        .msg_blk   (msg_blk),
        .msg_data  (msg_data)
    );

    // responses take priority over new requests
    assign rsp_bit   = N_PROC'(1) << rsp_src;
    assign rsp_ready = pend_v && slot_free;
    assign rsp_fire  = rsp_valid && rsp_ready;
    assign wait_next = pend_wait & ~rsp_bit;
    assign finish    = rsp_fire && (wait_next == '0);

    assign blocked = rsp_fire
                  || (pend_v && (req_blk == pend_blk))
                  || (pend_v && d_need_pend)
                  || (d_emit && !slot_free);
    assign req_ready = !rst && !blocked;
    assign req_fire  = req_valid && req_ready;

    always_comb begin
        we      = 1'b0;
        w_blk   = req_blk;
        w_st    = d_st;
        w_shr   = d_shr;
        wm_en   = 1'b0;
        wm_data = req_data;
        o_load  = 1'b0;
        o_kind  = d_kind;
        o_mask  = d_mask;
        o_blk   = req_blk;
        o_data  = d_data;
        if (finish) begin
            we     = 1'b1;
            w_blk  = pend_blk;
            w_st   = pend_read ? ST_SHR : ST_EXC;
            w_shr  = pend_read ? (pend_owner | pend_req) : pend_req;
            wm_en  = pend_fetch;
            wm_data = rsp_data;
            o_load = 1'b1;
            o_kind = pend_read ? MS_DATA_SH : MS_DATA_EX;
            o_mask = pend_req;
            o_blk  = pend_blk;
            o_data = pend_fetch ? rsp_data : pend_mem;
        end else if (req_fire) begin
            we     = d_upd;
            wm_en  = d_mem_wr;
            o_load = d_emit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v     <= 1'b0;
            pend_blk   <= '0;
            pend_req   <= '0;
            pend_read  <= 1'b0;
            pend_fetch <= 1'b0;
            pend_wait  <= '0;
            pend_owner <= '0;
        end else if (rsp_fire) begin
            pend_wait <= wait_next;
            if (finish) pend_v <= 1'b0;
        end else if (req_fire && d_need_pend) begin
            pend_v     <= 1'b1;
            pend_blk   <= req_blk;
            pend_req   <= N_PROC'(1) << req_src;
            pend_read  <= (req_kind == RQ_READ);
            pend_fetch <= d_fetch;
            pend_wait  <= d_wait;
            pend_owner <= d_wait;
        end
    end

    // R9
    same_block_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_v && req_fire) |-> (req_blk != pend_blk));

    // R5
    pending_has_waiters_chk: assert property (@(posedge clk) disable iff (rst)
        pend_v |-> (pend_wait != '0));

    // R5 R7
    grant_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_v && o_load && o_blk == pend_blk && o_kind != MS_INVAL && o_kind != MS_FETCH)
            |-> finish);

endmodule

// File: tb/dirc_home_bench.sv
`timescale 1ns/1ps
module dirc_home_bench;

    localparam int NP = 4;
    localparam int NB = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [1:0]    req_src = '0;
    logic [2:0]    req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_valid = 1'b0;
    logic          rsp_ready;
    logic [1:0]    rsp_src = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [1:0]    msg_kind;
    logic [NP-1:0] msg_mask;
    logic [2:0]    msg_blk;
    logic [DW-1:0] msg_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dirc_home #(.N_PROC(NP), .N_BLOCKS(NB), .DATA_W(DW)) u_dirc_home (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_src(rsp_src), .rsp_data(rsp_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_mask(msg_mask), .msg_blk(msg_blk), .msg_data(msg_data)
    );

    // kind(2) src(2) blk(3) data(16) expect(1) ekind(2) emask(4) edata(16)
    localparam int VN = 8;
    localparam logic [45:0] TBL [VN] = '{
        {2'd0, 2'd0, 3'd1, 16'h0000, 1'b1, 2'd0, 4'b0001, 16'd4},   // R2 read uncached
        {2'd0, 2'd2, 3'd1, 16'h0000, 1'b1, 2'd0, 4'b0100, 16'd4},   // R2 read shared
        {2'd1, 2'd3, 3'd2, 16'h0000, 1'b1, 2'd1, 4'b1000, 16'd7},   // R3 write uncached
        {2'd2, 2'd3, 3'd2, 16'h0055, 1'b0, 2'd0, 4'b0000, 16'd0},   // R4 write-back
        {2'd0, 2'd1, 3'd2, 16'h0000, 1'b1, 2'd0, 4'b0010, 16'h0055},// R4 data kept
        {2'd1, 2'd1, 3'd2, 16'h0000, 1'b1, 2'd1, 4'b0010, 16'h0055},// R6 sole sharer
        {2'd2, 2'd1, 3'd2, 16'h0066, 1'b0, 2'd0, 4'b0000, 16'd0},   // R4 write-back
        {2'd1, 2'd0, 3'd7, 16'h0000, 1'b1, 2'd1, 4'b0001, 16'd22}   // R3 write uncached
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_msg(input string tag, input logic [1:0] k,
                              input logic [NP-1:0] m, input logic [DW-1:0] d);
        check({tag, " valid"}, 32'(msg_valid), 32'd1);
        check({tag, " kind"},  32'(msg_kind),  32'(k));
        check({tag, " mask"},  32'(msg_mask),  32'(m));
        check({tag, " data"},  32'(msg_data),  32'(d));
    endtask

    task automatic do_req(input logic [1:0] k, input logic [1:0] s,
                          input logic [2:0] b, input logic [DW-1:0] d);
        @(negedge clk);
        req_kind = k; req_src = s; req_blk = b; req_data = d; req_valid = 1'b1;
        #1;
        for (int n = 0; n < 50 && !req_ready; n++) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic do_rsp(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        rsp_src = s; rsp_data = d; rsp_valid = 1'b1;
        #1;
        for (int n = 0; n < 50 && !rsp_ready; n++) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 msg_valid", 32'(msg_valid), 32'd0);
        check("R1 req_ready", 32'(req_ready), 32'd1);
        check("R1 rsp_ready", 32'(rsp_ready), 32'd0);

        // table walk
        for (int i = 0; i < VN; i++) begin
            logic [45:0] v;
            v = TBL[i];
            do_req(v[45:44], v[43:42], v[41:39], v[38:23]);
            if (v[22]) expect_msg($sformatf("R2-R6 vec%0d", i), v[21:20], v[19:16], v[15:0]);
            else check($sformatf("R4 vec%0d no msg", i), 32'(msg_valid), 32'd0);
        end

        // R5 write to shared block held by p0,p2 from p0
        do_req(2'd1, 2'd0, 3'd1, '0);
        expect_msg("R5 inval others", 2'd2, 4'b0100, 16'd0);
        // R9 other block proceeds (block 5 seed 16)
        do_req(2'd0, 2'd3, 3'd5, '0);
        expect_msg("R9 other block", 2'd0, 4'b1000, 16'd16);
        // R9 same block stalls
        @(negedge clk);
        req_kind = 2'd0; req_src = 2'd1; req_blk = 3'd1; req_valid = 1'b1;
        #1;
        check("R9 stall", 32'(req_ready), 32'd0);
        @(negedge clk); #1;
        check("R9 stall held", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        do_rsp(2'd2, '0);
        expect_msg("R5 grant after ack", 2'd1, 4'b0001, 16'd4);

        // R7 read of exclusive block
        do_req(2'd0, 2'd1, 3'd1, '0);
        expect_msg("R7 fetch", 2'd3, 4'b0001, 16'd0);
        do_rsp(2'd0, 16'h0099);
        expect_msg("R7 data", 2'd0, 4'b0010, 16'h0099);
        do_req(2'd0, 2'd2, 3'd1, '0);
        expect_msg("R7 memory updated", 2'd0, 4'b0100, 16'h0099);

        // R5 three sharers, requester outside the set
        do_req(2'd1, 2'd3, 3'd1, '0);
        expect_msg("R5 inval three", 2'd2, 4'b0111, 16'd0);
        do_rsp(2'd1, '0);
        check("R5 partial ack 1", 32'(msg_valid), 32'd0);
        do_rsp(2'd0, '0);
        check("R5 partial ack 2", 32'(msg_valid), 32'd0);
        do_rsp(2'd2, '0);
        expect_msg("R5 final grant", 2'd1, 4'b1000, 16'h0099);

        // R8 write of exclusive block
        do_req(2'd1, 2'd2, 3'd1, '0);
        expect_msg("R8 fetch", 2'd3, 4'b1000, 16'd0);
        do_rsp(2'd3, 16'h0077);
        expect_msg("R8 data", 2'd1, 4'b0100, 16'h0077);
        do_req(2'd2, 2'd2, 3'd1, 16'h0078);
        check("R4 wb no msg", 32'(msg_valid), 32'd0);
        do_req(2'd0, 2'd0, 3'd1, '0);
        expect_msg("R4 after wb", 2'd0, 4'b0001, 16'h0078);

        // R10 back-pressure on the message channel (block 3 seed 10)
        @(negedge clk);
        msg_ready = 1'b0;
        do_req(2'd0, 2'd1, 3'd3, '0);
        expect_msg("R10 first", 2'd0, 4'b0010, 16'd10);
        @(negedge clk);
        req_kind = 2'd0; req_src = 2'd0; req_blk = 3'd4; req_valid = 1'b1;
        #1;
        expect_msg("R10 held", 2'd0, 4'b0010, 16'd10);
        check("R10 req blocked", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        msg_ready = 1'b1;
        @(negedge clk); #1;
        check("R10 drained", 32'(msg_valid), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule